// File: doc/BRIEF.md
# Write-Once Snooping Line-State Controller

This block holds the coherence state of a small set of cache lines for one cache on a snooping bus. The protocol is write-once. The first local write to a clean line goes straight through to memory and leaves the line exclusive and clean. Later writes stay in the cache and mark the line dirty.

Each cycle the block accepts one local processor operation and one snooped bus event. The local operation is a read, a write or an eviction. The snooped event is a remote read or a remote write. Each one carries the index of the line it concerns.

One cycle later the block presents the following:

- the updated state of every line;
- a hit flag for the local operation;
- the bus actions that the pair of events requires: a fill from memory, a write-through, a write-back for an eviction, and a flush that supplies snooped dirty data.

Data arrays, bus arbitration and memory are not part of the block.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after it, every line reads Invalid and every bus and hit output is 0. Line state codes on `line_st` are 00 Invalid, 01 Shared-clean, 10 Exclusive-clean, 11 Dirty, with line i in bits [2i+1:2i].
- R2: A local read (`cpu_op`=01) reports hit when the line is not Invalid and leaves its state unchanged. A read of an Invalid line raises `bus_fill` and moves the line to Shared-clean.
- R3: A local write (`cpu_op`=10) to an Invalid or Shared-clean line raises `bus_wt` and moves the line to Exclusive-clean.
- R4: A local write to an Exclusive-clean or Dirty line moves it to Dirty and raises no bus output. Dirty is entered from no state other than Exclusive-clean.
- R5: A snooped remote read (`snp_op`=01) of a Dirty line raises `bus_snp_wb` and moves the line to Shared-clean. The same event moves an Exclusive-clean line to Shared-clean silently and leaves Shared-clean and Invalid lines unchanged.
- R6: A snooped remote write (`snp_op`=10) makes the line Invalid. If the line was Dirty, `bus_snp_wb` is also raised.
- R7: An eviction (`cpu_op`=11) makes the line Invalid. It raises `bus_ev_wb` only if the line was Dirty; clean lines are dropped with no bus output.
- R8: When the local operation and a snooped event name the same line in one cycle, the snooped event is applied first. The local operation then acts on the resulting state, so both of their bus outputs may rise together.
- R9: `cpu_op`=00 and `snp_op` values 00 or 11 have no effect: no state changes and no bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 2 | Local operation: 00 none, 01 read, 10 write, 11 evict |
| cpu_idx | input | IDX_W | Line addressed by the local operation |
| snp_op | input | 2 | Snooped event: 01 remote read, 10 remote write, else none |
| snp_idx | input | IDX_W | Line addressed by the snooped event |
| cpu_hit | output | 1 | Local operation found the line valid |
| bus_fill | output | 1 | Fetch line from memory for a read miss |
| bus_wt | output | 1 | Write the local store through to memory |
| bus_ev_wb | output | 1 | Write back a dirty line on eviction |
| bus_snp_wb | output | 1 | Flush dirty data in answer to a snooped event |
| line_st | output | 2*LINES | Registered state of every line |

## Verification
A snooped event and a local operation can fall in the same cycle. They can name the same line, or they can name two different lines and each ask for a write-back. The bench provokes both cases on purpose in directed steps, and again at random by drawing both indices from a small range. A behavioural model applies the snoop before the local operation, and every output and line state is compared against it on every clock. This shows whether the flush and the write-through (or fill) rise together and whether the final state is the one the ordering gives.

// File: rtl/wonce_pkg.sv
package wonce_pkg;

    typedef enum logic [1:0] {
        LS_INV   = 2'b00,
        LS_SHR   = 2'b01,
        LS_EXCL  = 2'b10,
        LS_DIRTY = 2'b11
    } line_st_t;

    localparam logic [1:0] CPU_NOP   = 2'b00;
    localparam logic [1:0] CPU_RD    = 2'b01;
    localparam logic [1:0] CPU_WR    = 2'b10;
    localparam logic [1:0] CPU_EVICT = 2'b11;

    localparam logic [1:0] SNP_NOP = 2'b00;
    localparam logic [1:0] SNP_RD  = 2'b01;
    localparam logic [1:0] SNP_WR  = 2'b10;

    typedef struct packed {
        line_st_t st;
        logic     sup_wb;
        logic     hit;
        logic     fill;
        logic     wt;
        logic     ev_wb;
    } line_nxt_t;

    typedef struct packed {
        logic hit;
        logic fill;
        logic wt;
        logic ev_wb;
        logic snp_wb;
    } bus_out_t;

endpackage

// File: rtl/wonce_idx_dec.sv
module wonce_idx_dec #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] sel
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = en && (idx == W'(i));
    end
endmodule

// File: rtl/wonce_line_fsm.sv
module wonce_line_fsm
    import wonce_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     snp_rd,
    input  logic     snp_wr,
    input  logic     loc_rd,
    input  logic     loc_wr,
    input  logic     loc_ev,
    output line_st_t st_q,
    output logic     sup_wb,
    output logic     loc_hit,
    output logic     loc_fill,
    output logic     loc_wt,
    output logic     loc_ev_wb
);
    line_nxt_t nx_d;
    line_st_t  mid;

    always_comb begin
        nx_d = '0;
        mid  = st_q;
        // snooped event is ordered ahead of the local operation
        if (snp_rd) begin
            if (st_q == LS_DIRTY) begin
                nx_d.sup_wb = 1'b1;
                mid         = LS_SHR;
            end else if (st_q == LS_EXCL) begin
                mid = LS_SHR;
            end
        end else if (snp_wr) begin
            if (st_q == LS_DIRTY) nx_d.sup_wb = 1'b1;
            mid = LS_INV;
        end
        nx_d.st = mid;
        if (loc_rd || loc_wr || loc_ev) nx_d.hit = (mid != LS_INV);
        if (loc_rd) begin
            if (mid == LS_INV) begin
                nx_d.fill = 1'b1;
                nx_d.st   = LS_SHR;
            end
        end else if (loc_wr) begin
            if (mid == LS_INV || mid == LS_SHR) begin
                nx_d.wt = 1'b1;
                nx_d.st = LS_EXCL;
            end else begin
                nx_d.st = LS_DIRTY;
            end
        end else if (loc_ev) begin
            if (mid == LS_DIRTY) nx_d.ev_wb = 1'b1;
            nx_d.st = LS_INV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LS_INV;
        else        st_q <= nx_d.st;
    end

    assign sup_wb    = nx_d.sup_wb;
    assign loc_hit   = nx_d.hit;
    assign loc_fill  = nx_d.fill;
    assign loc_wt    = nx_d.wt;
    assign loc_ev_wb = nx_d.ev_wb;

    AST_DIRTY_FROM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_DIRTY && $past(st_q) != LS_DIRTY) |-> $past(st_q) == LS_EXCL); // R4

    AST_SNPWR_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_wr && !loc_rd && !loc_wr) |=> st_q == LS_INV); // R6

endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
    import wonce_pkg::*;
#(
    parameter  int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cpu_op,
    input  logic [IDX_W-1:0]   cpu_idx,
    input  logic [1:0]         snp_op,
    input  logic [IDX_W-1:0]   snp_idx,
    output logic               cpu_hit,
    output logic               bus_fill,
    output logic               bus_wt,
    output logic               bus_ev_wb,
    output logic               bus_snp_wb,
    output logic [2*LINES-1:0] line_st
);
    logic [LINES-1:0] csel, ssel;
    logic [LINES-1:0] sup_wb_v, hit_v, fill_v, wt_v, ev_wb_v;
    bus_out_t out_d, out_q;

    wonce_idx_dec #(.N(LINES), .W(IDX_W)) u_cdec (
        .en(cpu_op != CPU_NOP), .idx(cpu_idx), .sel(csel));
    wonce_idx_dec #(.N(LINES), .W(IDX_W)) u_sdec (
        .en(snp_op == SNP_RD || snp_op == SNP_WR), .idx(snp_idx), .sel(ssel));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_t st_i;
        wonce_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .snp_rd   (ssel[i] && snp_op == SNP_RD),
            .snp_wr   (ssel[i] && snp_op == SNP_WR),
            .loc_rd   (csel[i] && cpu_op == CPU_RD),
            .loc_wr   (csel[i] && cpu_op == CPU_WR),
            .loc_ev   (csel[i] && cpu_op == CPU_EVICT),
            .st_q     (st_i),
            .sup_wb   (sup_wb_v[i]),
            .loc_hit  (hit_v[i]),
            .loc_fill (fill_v[i]),
            .loc_wt   (wt_v[i]),
            .loc_ev_wb(ev_wb_v[i])
        );
        assign line_st[2*i +: 2] = st_i;
    end

    always_comb begin
        out_d.hit    = |hit_v;
        out_d.fill   = |fill_v;
        out_d.wt     = |wt_v;
        out_d.ev_wb  = |ev_wb_v;
        out_d.snp_wb = |sup_wb_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cpu_hit    = out_q.hit;
    assign bus_fill   = out_q.fill;
    assign bus_wt     = out_q.wt;
    assign bus_ev_wb  = out_q.ev_wb;
    assign bus_snp_wb = out_q.snp_wb;

    AST_FILL_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fill |-> ($past(cpu_op) == CPU_RD && !cpu_hit)); // R2
    AST_WT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wt |-> $past(cpu_op) == CPU_WR); // R3
    AST_EVWB_ONLY_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ev_wb |-> ($past(cpu_op) == CPU_EVICT && cpu_hit)); // R7
    AST_SNPWB_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_snp_wb |-> ($past(snp_op) == SNP_RD || $past(snp_op) == SNP_WR)); // R5
    AST_LOCAL_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_fill, bus_wt, bus_ev_wb})); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == CPU_NOP && (snp_op == SNP_NOP || snp_op == 2'b11)) |=> $stable(line_st)); // R9

endmodule

// File: tb/tb_wonce_coh_ctrl.sv
`timescale 1ns/100ps
module tb_wonce_coh_ctrl;
    localparam int LINES = 4;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cpu_op = 2'b00;
    logic [IW-1:0] cpu_idx = '0;
    logic [1:0]    snp_op = 2'b00;
    logic [IW-1:0] snp_idx = '0;
    logic          cpu_hit, bus_fill, bus_wt, bus_ev_wb, bus_snp_wb;
    logic [2*LINES-1:0] line_st;

    always #2.5 clk = ~clk;

    wonce_coh_ctrl #(.LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .snp_op(snp_op), .snp_idx(snp_idx), .cpu_hit(cpu_hit),
        .bus_fill(bus_fill), .bus_wt(bus_wt), .bus_ev_wb(bus_ev_wb),
        .bus_snp_wb(bus_snp_wb), .line_st(line_st));

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int ms [LINES];
    logic [4:0] e_out;
    logic [2*LINES-1:0] e_st;
    bit pending = 0;
    string tag = "R1";

    function automatic logic [2*LINES-1:0] pack_model();
        logic [2*LINES-1:0] v = '0;
        for (int i = 0; i < LINES; i++) v[2*i +: 2] = 2'(ms[i]);
        return v;
    endfunction

    task automatic compare(string t);
        logic [4:0] got;
        got = {cpu_hit, bus_fill, bus_wt, bus_ev_wb, bus_snp_wb};
        n_run++;
        if (line_st !== e_st) begin
            n_fail++;
            $display("FAIL %s line states actual=%b expected=%b", t, line_st, e_st);
        end
        n_run++;
        if (got !== e_out) begin
            n_fail++;
            $display("FAIL %s hit/fill/wt/evwb/snpwb actual=%b expected=%b", t, got, e_out);
        end
    endtask

    // requirement tag chosen from the stimulus and the model's prior state
    function automatic string pick_tag(int cop, int ci, int sop, int si);
        if (cop != 0 && (sop == 1 || sop == 2) && ci == si) return "R8";
        if (sop == 1) return "R5";
        if (sop == 2) return "R6";
        if (cop == 1) return "R2";
        if (cop == 2) return (ms[ci] < 2) ? "R3" : "R4";
        if (cop == 3) return "R7";
        return "R9";
    endfunction

    task automatic step(int cop, int ci, int sop, int si);
        bit h = 0, f = 0, w = 0, e = 0, s = 0;
        @(negedge clk);
        if (pending) compare(tag);
        cpu_op = 2'(cop); cpu_idx = IW'(ci);
        snp_op = 2'(sop); snp_idx = IW'(si);
        tag = pick_tag(cop, ci, sop, si);
        // remote event first
        if (sop == 1) begin
            if (ms[si] == 3) begin s = 1; ms[si] = 1; end
            else if (ms[si] == 2) ms[si] = 1;
        end else if (sop == 2) begin
            if (ms[si] == 3) s = 1;
            ms[si] = 0;
        end
        if (cop != 0) h = (ms[ci] != 0);
        case (cop)
            1: if (ms[ci] == 0) begin f = 1; ms[ci] = 1; end
            2: if (ms[ci] <= 1) begin w = 1; ms[ci] = 2; end else ms[ci] = 3;
            3: begin if (ms[ci] == 3) e = 1; ms[ci] = 0; end
            default: ;
        endcase
        e_out = {h, f, w, e, s};
        e_st = pack_model();
        pending = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) ms[i] = 0;
        repeat (3) @(negedge clk);
        e_out = '0; e_st = '0;
        compare("R1");               // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");               // R1 after release
        // line 0 walk-through
        step(1, 0, 0, 0);            // R2 read miss -> fill, shared
        step(1, 0, 0, 0);            // R2 read hit
        step(2, 0, 0, 0);            // R3 shared -> exclusive, write-through
        step(2, 0, 0, 0);            // R4 exclusive -> dirty
        step(2, 0, 0, 0);            // R4 dirty stays dirty
        step(0, 0, 1, 0);            // R5 snoop read of dirty -> flush, shared
        step(0, 0, 2, 0);            // R6 snoop write of shared -> invalid
        step(2, 0, 0, 0);            // R3 write to invalid -> write-through
        step(2, 0, 0, 0);            // R4
        step(0, 0, 2, 0);            // R6 snoop write of dirty -> flush then invalid
        step(2, 0, 0, 0);
        step(2, 0, 0, 0);
        step(3, 0, 0, 0);            // R7 evict dirty -> write-back
        step(1, 0, 0, 0);
        step(3, 0, 0, 0);            // R7 evict shared silently
        step(3, 0, 0, 0);            // R7 evict invalid
        step(2, 1, 0, 0);
        step(0, 0, 1, 1);            // R5 exclusive -> shared silently
        step(0, 0, 1, 1);            // R5 shared unchanged
        step(0, 0, 3, 1);            // R9 reserved snoop code
        step(0, 2, 0, 2);            // R9 idle
        // same-line collisions
        step(2, 2, 0, 0); step(2, 2, 0, 0);
        step(2, 2, 1, 2);            // R8 flush and write-through together
        step(2, 2, 0, 0);
        step(1, 2, 2, 2);            // R8 flush then refill
        // two lines each needing a write-back
        step(2, 3, 0, 0); step(2, 3, 0, 0);
        step(2, 2, 0, 0); step(2, 2, 0, 0);
        step(3, 3, 1, 2);            // R7 and R5 in one cycle
        for (int k = 0; k < 3000; k++)
            step($urandom_range(0, 3), $urandom_range(0, LINES-1),
                 $urandom_range(0, 3), $urandom_range(0, LINES-1));
        step(0, 0, 0, 0);
        @(negedge clk);
        compare(tag);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule